// File: doc/BRIEF.md
# Boundary-Scan Instruction Lock

This block sits beside the instruction decoder of a boundary-scan test access port and lets software close the port with a secret code. Two extra instructions are added. The first stores a code in a lock register. The second stores a candidate in a key register. An equality comparator between the two registers drives a status output. While the registers disagree the port is closed, and every instruction other than the key-loading one is decoded as the harmless bypass instruction. The data path is then the one-bit bypass register.

A single shift register is shared by the lock and key operations. It is cleared when data capture starts under either instruction, and then filled from the serial input, least significant bit first. The update step copies it to the lock register or to the key register. Writing a lock also zeroes the key register, so any nonzero lock closes the port at once. A zero lock leaves the port open.

A lock instruction issued while the port is closed is demoted to bypass, so it cannot overwrite the code. Only the correct key reopens the port. The lock and key registers are cleared only by the power-on reset. Resetting the test logic therefore does not release the lock.

Top module: `scan_lock_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low) the port is open (`locked`=0) and `eff_ir` equals `ir_code`. This holds even when the port was closed before the reset.
- R2: Opcodes (4-bit default) are: 4'b1111 bypass, 4'b0000 external test, 4'b0001 sample, 4'b1010 lock, 4'b1011 unlock. `dp_sel` is 0 for the bypass path, 1 for the boundary path and 2 for the key/lock path. Every unlisted opcode selects the bypass path.
- R3: When the effective instruction is lock or unlock, a cycle with `cap_dr` high clears the shift register, so `kl_tdo` reads 0 afterwards.
- R4: During `shf_dr` under lock or unlock, `tdi` enters the most significant bit and the register moves toward bit 0, which drives `kl_tdo`. After KEY_W shifts, `kl_tdo` shows the first bit shifted in.
- R5: `upd_dr` under an effective lock copies the shift register into the lock register and clears the key register. A nonzero code therefore raises `locked`.
- R6: A lock code of zero leaves `locked` low.
- R7: While `locked` is high, every opcode except unlock yields `eff_ir` = 4'b1111 and `dp_sel` = 0. Unlock passes through with `dp_sel` = 2.
- R8: `upd_dr` under unlock copies the shift register into the key register. `locked` falls if the key equals the lock code and stays high otherwise. Once the port is open, other opcodes decode normally again.
- R9: A lock scan while the port is closed changes nothing, even with a zero code: `locked` stays high and only the original code opens the port. After a correct unlock, a new lock takes effect.
- R10: Capture and shift cycles under any instruction other than lock or unlock leave the shift register, and so `kl_tdo`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low; the only clear of the lock and key registers |
| cap_dr | input | 1 | Controller is in the data-capture state |
| shf_dr | input | 1 | Controller is in the data-shift state |
| upd_dr | input | 1 | Controller is in the data-update state |
| ir_code | input | IR_W | Opcode held in the instruction register |
| tdi | input | 1 | Serial test data in |
| eff_ir | output | IR_W | Opcode after lock mapping |
| dp_sel | output | 2 | Serial output path select: 0 bypass, 1 boundary, 2 key/lock |
| kl_tdo | output | 1 | Serial output of the key/lock shift register |
| locked | output | 1 | High while the lock and key registers differ |

## Verification
The lock-instruction demotion and the lock-register write can fall in the same update cycle. A lock scan with a zero code is issued while the port is closed, and it is judged by `locked` staying high and by a later zero-key unlock still failing. The comparator release and the decode of the held instruction also meet in one step. An unlock with the right code is followed at once by a check that an external-test opcode is no longer turned into bypass.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [1:0] {
        DP_BYP = 2'd0,
        DP_BSR = 2'd1,
        DP_KEY = 2'd2
    } dpath_e;
endpackage

// File: rtl/lock_decode.sv
module lock_decode
    import lock_pkg::*;
#(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [IR_W-1:0] OP_EXTEST = '0,
    parameter logic [IR_W-1:0] OP_SAMPLE = 1,
    parameter logic [IR_W-1:0] OP_LOCK   = 10,
    parameter logic [IR_W-1:0] OP_UNLOCK = 11
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [IR_W-1:0] ir_code,
    input  logic            locked,
    output logic [IR_W-1:0] eff_ir,
    output dpath_e          dp_sel,
    output logic            kl_sel,
    output logic            lock_op,
    output logic            unlock_op
);
    // instruction mapping: closed port demotes all but unlock
    always_comb begin
        if (locked && (ir_code != OP_UNLOCK))
            eff_ir = OP_BYPASS;
        else
            eff_ir = ir_code;
    end

    always_comb begin
        lock_op   = (eff_ir == OP_LOCK);
        unlock_op = (eff_ir == OP_UNLOCK);
        kl_sel    = lock_op || unlock_op;
        if (kl_sel)
            dp_sel = DP_KEY;
        else if ((eff_ir == OP_EXTEST) || (eff_ir == OP_SAMPLE))
            dp_sel = DP_BSR;
        else
            dp_sel = DP_BYP;
    end

    p_closed_bypass_r7: assert property (@(posedge clk) disable iff (!por_n)
        (locked && ir_code != OP_UNLOCK) |-> (dp_sel == DP_BYP));
endmodule

// File: rtl/lock_shift.sv
module lock_shift #(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             kl_sel,
    input  logic             cap_dr,
    input  logic             shf_dr,
    input  logic             tdi,
    output logic [KEY_W-1:0] sr_q,
    output logic             kl_tdo
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            sr_q <= '0;
        else if (kl_sel && cap_dr)
            sr_q <= '0;
        else if (kl_sel && shf_dr)
            sr_q <= {tdi, sr_q[KEY_W-1:1]};
    end

    assign kl_tdo = sr_q[0];

    p_shift_in_msb_r4: assert property (@(posedge clk) disable iff (!por_n)
        (kl_sel && shf_dr && !cap_dr) |=> (sr_q[KEY_W-1] == $past(tdi)));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        !kl_sel |=> $stable(sr_q));
endmodule

// File: rtl/lock_store.sv
module lock_store #(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             upd_dr,
    input  logic             lock_op,
    input  logic             unlock_op,
    input  logic [KEY_W-1:0] sr_q,
    output logic             locked
);
    logic [KEY_W-1:0] lock_q;
    logic [KEY_W-1:0] key_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q <= '0;
            key_q  <= '0;
        end else if (upd_dr && lock_op) begin
            lock_q <= sr_q;
            key_q  <= '0;
        end else if (upd_dr && unlock_op) begin
            key_q  <= sr_q;
        end
    end

    assign locked = (lock_q != key_q);

    p_zero_lock_open_r6: assert property (@(posedge clk) disable iff (!por_n)
        (upd_dr && lock_op && sr_q == '0) |=> !locked);
    p_lock_sets_r5: assert property (@(posedge clk) disable iff (!por_n)
        (upd_dr && lock_op && sr_q != '0) |=> locked);
    p_closed_keeps_code_r9: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> $stable(lock_q));
    p_good_key_opens_r8: assert property (@(posedge clk) disable iff (!por_n)
        (upd_dr && unlock_op && sr_q == lock_q) |=> !locked);
endmodule

// File: rtl/scan_lock_ctrl.sv
module scan_lock_ctrl
    import lock_pkg::*;
#(
    parameter int IR_W  = 4,
    parameter int KEY_W = 16,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [IR_W-1:0] OP_EXTEST = '0,
    parameter logic [IR_W-1:0] OP_SAMPLE = 1,
    parameter logic [IR_W-1:0] OP_LOCK   = 10,
    parameter logic [IR_W-1:0] OP_UNLOCK = 11
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            cap_dr,
    input  logic            shf_dr,
    input  logic            upd_dr,
    input  logic [IR_W-1:0] ir_code,
    input  logic            tdi,
    output logic [IR_W-1:0] eff_ir,
    output logic [1:0]      dp_sel,
    output logic            kl_tdo,
    output logic            locked
);
    dpath_e           dp_e;
    logic             kl_sel, lock_op, unlock_op;
    logic [KEY_W-1:0] sr_q;

    lock_decode #(
        .IR_W(IR_W), .OP_BYPASS(OP_BYPASS), .OP_EXTEST(OP_EXTEST),
        .OP_SAMPLE(OP_SAMPLE), .OP_LOCK(OP_LOCK), .OP_UNLOCK(OP_UNLOCK)
    ) u_dec (
        .clk(tck), .por_n(por_n), .ir_code(ir_code), .locked(locked),
        .eff_ir(eff_ir), .dp_sel(dp_e), .kl_sel(kl_sel),
        .lock_op(lock_op), .unlock_op(unlock_op)
    );

    lock_shift #(.KEY_W(KEY_W)) u_shift (
        .clk(tck), .por_n(por_n), .kl_sel(kl_sel), .cap_dr(cap_dr),
        .shf_dr(shf_dr), .tdi(tdi), .sr_q(sr_q), .kl_tdo(kl_tdo)
    );

    lock_store #(.KEY_W(KEY_W)) u_store (
        .clk(tck), .por_n(por_n), .upd_dr(upd_dr), .lock_op(lock_op),
        .unlock_op(unlock_op), .sr_q(sr_q), .locked(locked)
    );

    assign dp_sel = dp_e;

    p_capture_clears_r3: assert property (@(posedge tck) disable iff (!por_n)
        (cap_dr && dp_sel == 2'd2) |=> (kl_tdo == 1'b0));
endmodule

// File: tb/test_scan_lock_ctrl.sv
module test_scan_lock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IRW = 4;
    localparam int KW  = 16;
    localparam logic [3:0] BYP = 4'b1111, EXT = 4'b0000, SMP = 4'b0001,
                           LCK = 4'b1010, ULK = 4'b1011, ODD = 4'b0101;
    localparam int K_LOCKED = 0, K_EFF = 1, K_DP = 2, K_TDO = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic tck = 0, por_n = 0, cap_dr = 0, shf_dr = 0, upd_dr = 0, tdi = 0;
    logic [IRW-1:0] ir_code = EXT;
    logic [IRW-1:0] eff_ir;
    logic [1:0] dp_sel;
    logic kl_tdo, locked;
    int checks = 0, errors = 0;
    bit finished = 0;
    item_t sb[$];

    always #(CLK_PERIOD/2) tck = ~tck;

    scan_lock_ctrl #(.IR_W(IRW), .KEY_W(KW)) i_scan_lock_ctrl (
        .tck(tck), .por_n(por_n), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .upd_dr(upd_dr), .ir_code(ir_code), .tdi(tdi), .eff_ir(eff_ir),
        .dp_sel(dp_sel), .kl_tdo(kl_tdo), .locked(locked)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge tck) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_LOCKED: act = {31'd0, locked};
                K_EFF:    act = {28'd0, eff_ir};
                K_DP:     act = {30'd0, dp_sel};
                default:  act = {31'd0, kl_tdo};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic flush();
        @(negedge tck); #1;
    endtask

    task automatic step();
        @(posedge tck); #1;
    endtask

    task automatic dr_scan(input logic [3:0] op, input logic [31:0] data, input bit do_upd);
        ir_code = op;
        cap_dr = 1; step(); cap_dr = 0;
        shf_dr = 1;
        for (int i = 0; i < KW; i++) begin
            tdi = data[i]; step();
        end
        shf_dr = 0;
        if (do_upd) begin
            upd_dr = 1; step(); upd_dr = 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step(); por_n = 1; step();
        // R1 / R2 reset state and decode
        expect_item(K_LOCKED, 0, "R1"); expect_item(K_EFF, EXT, "R1");
        expect_item(K_DP, 1, "R2"); flush();
        ir_code = ODD; expect_item(K_DP, 0, "R2"); expect_item(K_EFF, ODD, "R2"); flush();
        ir_code = LCK; expect_item(K_DP, 2, "R2"); flush();
        ir_code = BYP; expect_item(K_DP, 0, "R2"); flush();
        // R3 / R4 capture clear and shifting (no update)
        ir_code = ULK; tdi = 1;
        shf_dr = 1; step(); shf_dr = 0;
        expect_item(K_TDO, 0, "R4 pre"); flush();
        cap_dr = 1; step(); cap_dr = 0;
        expect_item(K_TDO, 0, "R3"); flush();
        dr_scan(ULK, 32'h1236, 0);
        expect_item(K_TDO, 0, "R4"); flush();
        shf_dr = 1; tdi = 0; step(); shf_dr = 0;
        expect_item(K_TDO, 1, "R4"); expect_item(K_LOCKED, 0, "R4"); flush();
        // R10 capture/shift under another instruction leave it alone
        ir_code = EXT; cap_dr = 1; step(); cap_dr = 0;
        shf_dr = 1; tdi = 0; step(); step(); shf_dr = 0;
        expect_item(K_TDO, 1, "R10"); flush();
        // R6 zero lock stays open
        dr_scan(LCK, 32'h0, 1);
        expect_item(K_LOCKED, 0, "R6"); flush();
        // R5 / R7 nonzero lock closes and demotes
        dr_scan(LCK, 32'hBEEF, 1);
        expect_item(K_LOCKED, 1, "R5"); flush();
        ir_code = EXT; expect_item(K_EFF, BYP, "R7"); expect_item(K_DP, 0, "R7"); flush();
        ir_code = SMP; expect_item(K_EFF, BYP, "R7"); flush();
        ir_code = LCK; expect_item(K_EFF, BYP, "R7"); expect_item(K_DP, 0, "R7"); flush();
        ir_code = ULK; expect_item(K_EFF, ULK, "R7"); expect_item(K_DP, 2, "R7"); flush();
        // R8 wrong key
        dr_scan(ULK, 32'hBEEE, 1);
        expect_item(K_LOCKED, 1, "R8 wrong key"); flush();
        // R9 lock while closed has no effect
        dr_scan(LCK, 32'h0, 1);
        expect_item(K_LOCKED, 1, "R9"); flush();
        dr_scan(ULK, 32'h0, 1);
        expect_item(K_LOCKED, 1, "R9 zero key"); flush();
        // R8 right key opens; decode restored
        dr_scan(ULK, 32'hBEEF, 1);
        expect_item(K_LOCKED, 0, "R8"); flush();
        ir_code = EXT; expect_item(K_EFF, EXT, "R8"); expect_item(K_DP, 1, "R8"); flush();
        // R9 relock after opening
        dr_scan(LCK, 32'h0F0F, 1);
        expect_item(K_LOCKED, 1, "R9 relock"); flush();
        dr_scan(ULK, 32'h0F0F, 1);
        expect_item(K_LOCKED, 0, "R8 second key"); flush();
        // R1 power-on reset opens a closed port
        dr_scan(LCK, 32'h0001, 1);
        expect_item(K_LOCKED, 1, "R5 low bit"); flush();
        por_n = 0; step(); por_n = 1; step();
        ir_code = SMP;
        expect_item(K_LOCKED, 0, "R1 por"); expect_item(K_EFF, SMP, "R1 por"); flush();
        flush();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule